// File: doc/BRIEF.md
# LIN Bus Remote Wake-Up Detector

This block runs while a LIN node sits in its lowest-power state. It looks at three things: the digitized LIN bus level from the bus comparator, a local wake input that is active low, and a chip-select input that has already been filtered. When one of them shows a valid wake pattern, the block sends a single one-cycle wake request to the mode controller. The mode controller arms the detector only while it reports power-down. Dropping the arm input clears all state inside the detector.

A compile-time parameter chooses how the bus can wake the node.
- **Falling-edge style:** a recessive-to-dominant edge followed by a dominant level that lasts the debounce time.
- **Rising-edge style:** a dominant period at least as long as the debounce time, then a return to recessive. In this style a bus that floats low and stays low can never wake the node.

Durations are counted in ticks of a microsecond time base, which is derived from the clock by a prescaler. Bus-voltage thresholding happens outside this block, and so does control of the regulator.

Top module: `lin_wake_detect`

## Requirements
- R1: While `arm` is low, `wake_req` stays low, whatever `bus_rx`, `wake_n` or `cs_filt` do.
- R2: In falling-edge style (`STYLE` = WAKE_ON_FALL, encoding 0), a 1-to-0 transition of `bus_rx` while armed, followed by `bus_rx` staying 0 for `FALL_TICKS` microsecond ticks, produces a wake request. The request comes while the bus is still low.
- R3: In falling-edge style, a low period shorter than the threshold produces no request. A bus that is already low when the detector is armed, with no falling edge seen while armed, also produces no request.
- R4: In rising-edge style (`STYLE` = WAKE_ON_RISE, encoding 1), a low period of at least `RISE_TICKS` ticks followed by a return of `bus_rx` to 1 produces a wake request. No request appears before the return to 1.
- R5: In rising-edge style, a low period shorter than the threshold produces no request when the bus returns high. A low level that never returns high never produces a request. The low-duration count saturates at the threshold.
- R6: A 1-to-0 transition of `wake_n` while armed produces a wake request. If `wake_n` was already low when the detector was armed, no request follows.
- R7: `cs_filt` at 1 while armed produces a wake request.
- R8: `wake_req` is high for exactly one cycle. There is at most one request per armed interval, even if several wake sources occur or a source stays active.
- R9: Disarming clears the low-duration count and the request-issued flag. Low time spent before a disarm is not carried into the next armed interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | High while the mode controller is in power-down |
| bus_rx | input | 1 | Bus comparator output, asynchronous (1 = recessive, 0 = dominant) |
| wake_n | input | 1 | Local wake input, asynchronous, active low |
| cs_filt | input | 1 | Chip-select level, already filtered and synchronous to `clk` |
| wake_req | output | 1 | One-cycle wake request to the mode controller |

## Verification
The bench runs a falling-edge instance and a rising-edge instance side by side and drives the same stimulus into both.

It probes each threshold from both sides:
- A design that counts the wrong number of ticks either wakes on a short glitch or misses a valid low period.
- A rising-style design that fires on the low level alone gives a request before the bus returns high, or gives one on a stuck-low bus.

It also covers these corner cases:
- **Inputs already active at arming.** A bus or wake input that is low before arming must not be seen as an edge.
- **Several sources at once.** Stacked wake sources must yield a single request.
- **Disarm in the middle of a low period.** A design that keeps its low count across a disarm would wake on the second short low period.

// File: rtl/lin_wake_pkg.sv
// Package: lin_wake_pkg
// Shared type selecting the bus wake style of the wake-up detector.
// Assumes nothing beyond a SystemVerilog-2017 compile.
package lin_wake_pkg;

    typedef enum logic {
        WAKE_ON_FALL = 1'b0,  // falling edge, then a debounced low
        WAKE_ON_RISE = 1'b1   // debounced low, then a rising edge
    } wake_style_e;

endpackage

// File: rtl/lin_wake_sync.sv
// Module: lin_wake_sync
// Two-flop synchronizer for asynchronous single-bit inputs.
// Assumes each input bit changes slowly compared with clk. RST_VAL is the
// idle level loaded at reset, so that no false edge appears after reset.
module lin_wake_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [0:0]  RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two register stages bring the input into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {WIDTH{RST_VAL}};
            sync_q <= {WIDTH{RST_VAL}};
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/lin_wake_tick.sv
// Module: lin_wake_tick
// Microsecond time base: pulses tick once every DIV clocks.
// restart forces the phase to zero so that a timed interval begins at a
// known clock. Assumes DIV >= 2.
module lin_wake_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] phase_q;

    // Tick marks the last clock of each DIV-clock period.
    assign tick = (phase_q == LAST);

    // Prescaler phase: wraps after each tick, zeroed on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/lin_wake_bus_qual.sv
// Module: lin_wake_bus_qual
// Qualifies a bus wake from the synchronized bus level.
// It times low periods in microsecond ticks and, depending on STYLE, fires
// either once the low after a falling edge reaches TH ticks, or on the
// rising edge that ends a low of at least TH ticks.
// Assumes bus_s is already synchronous. All state is held cleared while arm
// is low. The edge history keeps tracking while disarmed, so a level that
// was already present at arming is not taken for an edge.
module lin_wake_bus_qual
    import lin_wake_pkg::*;
#(
    parameter wake_style_e STYLE = WAKE_ON_FALL,
    parameter int          TH    = 20,
    parameter int          DIV   = 250,
    localparam int         CNT_W = $clog2(TH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             bus_s,
    output logic             bus_hit,
    output logic [CNT_W-1:0] low_cnt
);

    localparam logic [CNT_W-1:0] TH_C   = CNT_W'(TH);
    localparam logic [CNT_W-1:0] TH_M1  = CNT_W'(TH - 1);

    logic bus_prev_q;
    logic fall_e;
    logic rise_e;
    logic tick;
    logic run;
    logic [CNT_W-1:0] cnt_q;

    // Previous bus sample, kept updated in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_prev_q <= 1'b1;
        end else begin
            bus_prev_q <= bus_s;
        end
    end

    assign fall_e = bus_prev_q & ~bus_s;
    assign rise_e = ~bus_prev_q & bus_s;

    lin_wake_tick #(
        .DIV (DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (~arm | fall_e | rise_e),
        .tick    (tick)
    );

    generate
        if (STYLE == WAKE_ON_FALL) begin : g_fall
            logic run_q;

            // Falling style: low time counts only after an armed falling edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= 1'b0;
                end else if (!arm || bus_s) begin
                    run_q <= 1'b0;
                end else if (fall_e) begin
                    run_q <= 1'b1;
                end
            end

            assign run     = run_q;
            assign bus_hit = arm & run_q & tick & ~bus_s & (cnt_q == TH_M1);
        end else begin : g_rise
            // Rising style: any armed low counts; the edge that ends it decides.
            assign run     = 1'b1;
            assign bus_hit = arm & rise_e & (cnt_q == TH_C);
        end
    endgenerate

    // Low-duration counter: saturates at TH, cleared by a high or a disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm || bus_s || fall_e) begin
            cnt_q <= '0;
        end else if (run && tick && (cnt_q != TH_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign low_cnt = cnt_q;

endmodule

// File: rtl/lin_wake_detect.sv
// Module: lin_wake_detect (top)
// Remote and local wake-up detector used in power-down. It synchronizes the
// bus and local wake inputs, qualifies bus activity through lin_wake_bus_qual,
// detects local falling edges and chip-select high, and issues one
// single-cycle wake_req per armed interval.
// Assumes cs_filt is already filtered and synchronous to clk, and that TICK_DIV
// clocks make one microsecond.
module lin_wake_detect
    import lin_wake_pkg::*;
#(
    parameter wake_style_e STYLE      = WAKE_ON_FALL,
    parameter int          TICK_DIV   = 250,
    parameter int          FALL_TICKS = 20,
    parameter int          RISE_TICKS = 70,
    localparam int         TH_SEL     = (STYLE == WAKE_ON_RISE) ? RISE_TICKS : FALL_TICKS,
    localparam int         CNT_W      = $clog2(TH_SEL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic bus_rx,
    input  logic wake_n,
    input  logic cs_filt,
    output logic wake_req
);

    logic [1:0]       sync_s;
    logic             bus_s;
    logic             wake_s;
    logic             bus_hit;
    logic [CNT_W-1:0] low_cnt;
    logic             wake_prev_q;
    logic             loc_hit;
    logic             any_hit;
    logic             done_q;
    logic             req_q;

    lin_wake_sync #(
        .WIDTH   (2),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({wake_n, bus_rx}),
        .q_sync  (sync_s)
    );

    assign bus_s  = sync_s[0];
    assign wake_s = sync_s[1];

    lin_wake_bus_qual #(
        .STYLE (STYLE),
        .TH    (TH_SEL),
        .DIV   (TICK_DIV)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .bus_s   (bus_s),
        .bus_hit (bus_hit),
        .low_cnt (low_cnt)
    );

    // Local wake history, tracked in every mode so that a held-low input is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_prev_q <= 1'b1;
        end else begin
            wake_prev_q <= wake_s;
        end
    end

    assign loc_hit = wake_prev_q & ~wake_s;
    assign any_hit = arm & ~done_q & (bus_hit | loc_hit | cs_filt);

    // Request pulse plus issued flag; the flag holds until disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            req_q  <= any_hit;
            done_q <= arm & (done_q | any_hit);
        end
    end

    assign wake_req = req_q;

endmodule

// File: rtl/lin_wake_detect_chk.sv
// Module: lin_wake_detect_chk
// Checker bound to lin_wake_detect. It relates the request output to the
// arm and chip-select inputs, and checks the issued flag and the low-duration
// count.
module lin_wake_detect_chk #(
    parameter int TH    = 20,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             cs_filt,
    input logic             wake_req,
    input logic             done_q,
    input logic [CNT_W-1:0] low_cnt
);

    AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(arm)) else $error("request without arm"); // R1

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req) else $error("request longer than a cycle"); // R8

    AST_REQ_ONCE_PER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $past(done_q)) |-> !wake_req) else $error("second request"); // R8

    AST_CS_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && cs_filt && !done_q) |=> wake_req) else $error("chip select ignored"); // R7

    AST_LOW_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= CNT_W'(TH)) else $error("low count past threshold"); // R5

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (low_cnt == '0 && !done_q)) else $error("state kept after disarm"); // R9

endmodule

bind lin_wake_detect lin_wake_detect_chk #(
    .TH    (TH_SEL),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .cs_filt  (cs_filt),
    .wake_req (wake_req),
    .done_q   (done_q),
    .low_cnt  (low_cnt)
);

// File: tb/lin_wake_detect_tb.sv
`timescale 1ns/1ps
// Directed bench: a falling-style instance (u_dut) and a rising-style
// instance (u_dut_rise) receive the same stimulus. Pulses are counted per
// instance, and each scenario task checks its own counts.
module lin_wake_detect_tb;
    import lin_wake_pkg::*;

    localparam int DIV  = 5;
    localparam int FT   = 20;
    localparam int RT   = 70;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic bus_rx = 1'b1;
    logic wake_n = 1'b1;
    logic cs_filt = 1'b0;
    logic req_f;
    logic req_r;

    int n_f = 0;
    int n_r = 0;
    int long_f = 0;
    int long_r = 0;
    logic prev_f = 1'b0;
    logic prev_r = 1'b0;
    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lin_wake_detect #(
        .STYLE(WAKE_ON_FALL), .TICK_DIV(DIV), .FALL_TICKS(FT), .RISE_TICKS(RT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .bus_rx(bus_rx),
        .wake_n(wake_n), .cs_filt(cs_filt), .wake_req(req_f)
    );

    lin_wake_detect #(
        .STYLE(WAKE_ON_RISE), .TICK_DIV(DIV), .FALL_TICKS(FT), .RISE_TICKS(RT)
    ) u_dut_rise (
        .clk(clk), .rst_n(rst_n), .arm(arm), .bus_rx(bus_rx),
        .wake_n(wake_n), .cs_filt(cs_filt), .wake_req(req_r)
    );

    // Pulse monitor: counts requests and multi-cycle pulses per instance.
    always @(posedge clk) begin
        if (req_f) n_f <= n_f + 1;
        if (req_r) n_r <= n_r + 1;
        if (req_f && prev_f) long_f <= long_f + 1;
        if (req_r && prev_r) long_r <= long_r + 1;
        prev_f <= req_f;
        prev_r <= req_r;
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Return to idle, disarm, and zero the pulse counters.
    task automatic idle_reset;
        @(negedge clk);
        arm = 1'b0; bus_rx = 1'b1; wake_n = 1'b1; cs_filt = 1'b0;
        wait_cyc(10);
        n_f = 0; n_r = 0;
    endtask

    task automatic t_reset;
        wait_cyc(1);
        check("R1 reset wake_req falling", int'(req_f), 0);
        check("R1 reset wake_req rising", int'(req_r), 0);
    endtask

    task automatic t_disarmed;
        idle_reset();
        bus_rx = 1'b0; wait_cyc(RT * DIV + 40);
        bus_rx = 1'b1; wait_cyc(10);
        wake_n = 1'b0; wait_cyc(10);
        cs_filt = 1'b1; wait_cyc(20);
        check("R1 disarmed falling", n_f, 0);
        check("R1 disarmed rising", n_r, 0);
    endtask

    task automatic t_fall_ok;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        bus_rx = 1'b0; wait_cyc(FT * DIV + 20);
        check("R2 fall style wakes on held low", n_f, 1);
        check("R4 rise style silent while low", n_r, 0);
        bus_rx = 1'b1; wait_cyc(20);
        check("R5 rise style short low no wake", n_r, 0);
        check("R8 single pulse falling", n_f, 1);
    endtask

    task automatic t_fall_short;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        bus_rx = 1'b0; wait_cyc((FT - 2) * DIV);
        bus_rx = 1'b1; wait_cyc(FT * DIV);
        check("R3 short low no wake", n_f, 0);
    endtask

    task automatic t_fall_prelow;
        idle_reset();
        bus_rx = 1'b0; wait_cyc(10);
        arm = 1'b1; wait_cyc(3 * FT * DIV);
        check("R3 low before arm no wake", n_f, 0);
    endtask

    task automatic t_rise_ok;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        bus_rx = 1'b0; wait_cyc(RT * DIV + 30);
        check("R4 no request before bus high", n_r, 0);
        bus_rx = 1'b1; wait_cyc(10);
        check("R4 rise style wakes on return high", n_r, 1);
    endtask

    task automatic t_rise_stuck;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        bus_rx = 1'b0; wait_cyc(3 * RT * DIV);
        check("R5 stuck low no wake", n_r, 0);
    endtask

    task automatic t_local;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        wake_n = 1'b0; wait_cyc(10);
        check("R6 local edge falling inst", n_f, 1);
        check("R6 local edge rising inst", n_r, 1);
        idle_reset();
        wake_n = 1'b0; wait_cyc(10);
        arm = 1'b1; wait_cyc(50);
        check("R6 held local low at arm no wake", n_f, 0);
    endtask

    task automatic t_cs;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        cs_filt = 1'b1; wait_cyc(50);
        check("R7 chip select wakes", n_f, 1);
        check("R8 held chip select one pulse", n_r, 1);
    endtask

    task automatic t_multi;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        wake_n = 1'b0; wait_cyc(10);
        cs_filt = 1'b1; bus_rx = 1'b0; wait_cyc(RT * DIV + 20);
        bus_rx = 1'b1; wait_cyc(20);
        check("R8 stacked sources one pulse falling", n_f, 1);
        check("R8 stacked sources one pulse rising", n_r, 1);
        check("R8 pulse width falling", long_f, 0);
        check("R8 pulse width rising", long_r, 0);
    endtask

    task automatic t_clear;
        idle_reset();
        arm = 1'b1; wait_cyc(10);
        bus_rx = 1'b0; wait_cyc(60 * DIV);
        arm = 1'b0; wait_cyc(5);
        arm = 1'b1; wait_cyc(40 * DIV);
        bus_rx = 1'b1; wait_cyc(20);
        check("R9 disarm clears low count", n_r, 0);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_disarmed();
        t_fall_ok();
        t_fall_short();
        t_fall_prelow();
        t_rise_ok();
        t_rise_stuck();
        t_local();
        t_cs();
        t_multi();
        t_clear();
        idle_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule